// File: doc/BRIEF.md
# Self-Synchronizing Serial Bit Randomizer

This block whitens a serial bit stream with a 17-stage shift register and two taps, and the same module also undoes the whitening. A parameter fixes the role of each instance. In the scramble role the register feeds back the bits it has already sent, so the output looks pseudorandom even when the input is constant. In the descramble role the register holds the bits it has received, so the original data comes back. Because the descrambler uses only received bits, it corrects itself once 17 bits have passed through it, even if it started from a different seed.

One bit enters per cycle in which `in_valid` is high. The result leaves one cycle later on `out_bit`, marked by `out_valid`. On a cycle without `in_valid`, no register changes. This stands in for a gated register clock. A synchronous reset loads a fixed nonzero seed into the register.

Top module: `ssr_randomizer`

## Requirements
- R1: While `rst` is high at a clock edge, the register takes the value `SEED`, and `out_valid` and `out_bit` go low. Bit k-1 of `SEED` is stage k.
- R2: For an accepted bit d, `out_bit` on the next cycle equals d XOR stage `TAP_A` XOR stage `TAP_B`. The defaults are stages 12 and 17, and the stage values are those present before the shift.
- R3: On each accepted bit, stage k moves to stage k+1 for k from 1 to 16, and the content of stage 17 is dropped.
- R4: In scramble mode (`MODE` = 0), stage 1 takes the output bit just produced.
- R5: In descramble mode (`MODE` = 1), stage 1 takes the received input bit.
- R6: `out_valid` equals `in_valid` delayed by exactly one clock cycle.
- R7: A cycle with `in_valid` low changes neither the register nor `out_bit`. A stream broken by idle cycles therefore yields the same bits as the same stream sent without gaps.
- R8: A descrambler fed by a scrambler that has the same seed returns every data bit exactly, including when the stream has random idle gaps.
- R9: A descrambler whose seed differs from the scrambler's returns correct data from the 18th bit onward (zero-based index 17 and later).
- R10: An all-zero input stream through a scrambler with a nonzero seed does not give a constant output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset that loads the seed |
| in_valid | input | 1 | Qualifies `in_bit`; the register advances only when this is high |
| in_bit | input | 1 | Serial data bit in |
| out_valid | output | 1 | Marks `out_bit` as a new result |
| out_bit | output | 1 | Registered serial data bit out |

## Verification
The bench builds three instances with the default 17 stages and taps 12 and 17.

- A scrambler with seed 17'h1B5A3 is checked bit by bit against a bench model.
- A matched descrambler is chained to that scrambler, which brings exact recovery through random idle gaps within reach.
- A second descrambler with seed 17'h0F0F1 exposes the self-synchronizing behaviour. It is expected to recover the data only from bit 17 onward.
- The nonzero scrambler seed is what makes an all-zero input produce varied output.

// File: rtl/ssr_pkg.sv
package ssr_pkg;

   typedef enum logic {
      SSR_SCRAMBLE   = 1'b0,
      SSR_DESCRAMBLE = 1'b1
   } ssr_mode_e;

   function automatic logic [31:0] tap_mask(input int unsigned stages,
                                            input int unsigned tap_a,
                                            input int unsigned tap_b);
      logic [31:0] m;
      m = '0;
      if (tap_a >= 1 && tap_a <= stages) m[tap_a-1] = 1'b1;
      if (tap_b >= 1 && tap_b <= stages) m[tap_b-1] = 1'b1;
      return m;
   endfunction

endpackage

// File: rtl/ssr_stage_chain.sv
module ssr_stage_chain #(
   parameter int unsigned      STAGES = 17,
   parameter logic [STAGES-1:0] SEED  = '1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              adv,
   input  logic              load_bit,
   output logic [STAGES-1:0] state
);

   genvar k;
   generate
      for (k = 0; k < STAGES; k++) begin : g_stage
         logic nxt;
         if (k == 0) begin : g_head
            assign nxt = load_bit;
         end else begin : g_body
            assign nxt = state[k-1];
         end
         always_ff @(posedge clk) begin
            if (rst)      state[k] <= SEED[k];
            else if (adv) state[k] <= nxt;
         end
      end
   endgenerate

endmodule

// File: rtl/ssr_tap_mix.sv
module ssr_tap_mix #(
   parameter int unsigned STAGES = 17,
   parameter int unsigned TAP_A  = 12,
   parameter int unsigned TAP_B  = 17
) (
   input  logic [STAGES-1:0] state,
   input  logic              data,
   output logic              mixed
);

   localparam logic [31:0]       FULL_MASK = ssr_pkg::tap_mask(STAGES, TAP_A, TAP_B);
   localparam logic [STAGES-1:0] MASK      = FULL_MASK[STAGES-1:0];

   always_comb mixed = data ^ (^(state & MASK));

endmodule

// File: rtl/ssr_out_reg.sv
module ssr_out_reg (
   input  logic clk,
   input  logic rst,
   input  logic adv,
   input  logic d,
   output logic q,
   output logic vld
);

   always_ff @(posedge clk) begin
      if (rst) begin
         q   <= 1'b0;
         vld <= 1'b0;
      end else begin
         vld <= adv;
         if (adv) q <= d;
      end
   end

endmodule

// File: rtl/ssr_randomizer.sv
module ssr_randomizer #(
   parameter int unsigned        STAGES = 17,
   parameter int unsigned        TAP_A  = 12,
   parameter int unsigned        TAP_B  = 17,
   parameter logic [STAGES-1:0]  SEED   = 17'h1B5A3,
   parameter ssr_pkg::ssr_mode_e MODE   = ssr_pkg::SSR_SCRAMBLE
) (
   input  logic clk,
   input  logic rst,
   input  logic in_valid,
   input  logic in_bit,
   output logic out_valid,
   output logic out_bit
);

   localparam int unsigned LAST = STAGES - 1;

   generate
      if (STAGES < 2 || STAGES > 32) begin : g_bad_stages
         $error("ssr_randomizer: STAGES must be in 2..32");
      end
      if (TAP_A < 1 || TAP_A >= TAP_B) begin : g_bad_taps
         $error("ssr_randomizer: need 1 <= TAP_A < TAP_B");
      end
      if (TAP_B > STAGES) begin : g_bad_tapb
         $error("ssr_randomizer: TAP_B must not exceed STAGES");
      end
      if (SEED == '0) begin : g_bad_seed
         $error("ssr_randomizer: SEED must be nonzero");
      end
   endgenerate

   logic [LAST:0] sreg_q;
   logic          mixed;
   logic          load_bit;

   ssr_tap_mix #(
      .STAGES (STAGES),
      .TAP_A  (TAP_A),
      .TAP_B  (TAP_B)
   ) u_mix (
      .state (sreg_q),
      .data  (in_bit),
      .mixed (mixed)
   );

   generate
      if (MODE == ssr_pkg::SSR_SCRAMBLE) begin : g_feedback
         assign load_bit = mixed;
      end else begin : g_feedforward
         assign load_bit = in_bit;
      end
   endgenerate

   ssr_stage_chain #(
      .STAGES (STAGES),
      .SEED   (SEED)
   ) u_chain (
      .clk      (clk),
      .rst      (rst),
      .adv      (in_valid),
      .load_bit (load_bit),
      .state    (sreg_q)
   );

   ssr_out_reg u_out (
      .clk (clk),
      .rst (rst),
      .adv (in_valid),
      .d   (mixed),
      .q   (out_bit),
      .vld (out_valid)
   );

endmodule

// File: rtl/ssr_randomizer_chk.sv
module ssr_randomizer_chk #(
   parameter int unsigned        STAGES = 17,
   parameter int unsigned        TAP_A  = 12,
   parameter int unsigned        TAP_B  = 17,
   parameter logic [STAGES-1:0]  SEED   = 17'h1B5A3,
   parameter ssr_pkg::ssr_mode_e MODE   = ssr_pkg::SSR_SCRAMBLE
) (
   input logic              clk,
   input logic              rst,
   input logic              in_valid,
   input logic              in_bit,
   input logic              out_valid,
   input logic              out_bit,
   input logic [STAGES-1:0] state
);

   // R1: reset loads seed and clears the output
   a_r1_reset_seed: assert property (@(posedge clk)
      rst |=> (state == SEED) && !out_valid && !out_bit);

   // R2: output is input mixed with the two tap stages before the shift
   a_r2_out_mix: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_bit == $past(in_bit ^ state[TAP_A-1] ^ state[TAP_B-1]));

   // R3: stages move up by one on an accepted bit
   a_r3_shift_up: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> state[STAGES-1:1] == $past(state[STAGES-2:0]));

   generate
      if (MODE == ssr_pkg::SSR_SCRAMBLE) begin : g_chk_scr
         // R4: stage 1 holds the produced output bit
         a_r4_load_output: assert property (@(posedge clk) disable iff (rst)
            in_valid |=> state[0] == out_bit);
      end else begin : g_chk_dscr
         // R5: stage 1 holds the received bit
         a_r5_load_input: assert property (@(posedge clk) disable iff (rst)
            in_valid |=> state[0] == $past(in_bit));
      end
   endgenerate

   // R6: valid strobe delayed one cycle
   a_r6_valid_follow: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);
   a_r6_idle_follow: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);

   // R7: idle cycle freezes register and output bit
   a_r7_hold_state: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(state) && $stable(out_bit));

endmodule

bind ssr_randomizer ssr_randomizer_chk #(
   .STAGES (STAGES),
   .TAP_A  (TAP_A),
   .TAP_B  (TAP_B),
   .SEED   (SEED),
   .MODE   (MODE)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .in_bit    (in_bit),
   .out_valid (out_valid),
   .out_bit   (out_bit),
   .state     (sreg_q)
);

// File: tb/ssr_randomizer_tb.sv
module ssr_randomizer_tb;

   localparam int          CLK_PERIOD = 10;
   localparam logic [16:0] SEED_A     = 17'h1B5A3;
   localparam logic [16:0] SEED_B     = 17'h0F0F1;
   localparam int          MAXBITS    = 1024;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic tx_iv = 1'b0;
   logic tx_ib = 1'b0;
   logic tx_ov, tx_ob;
   logic rx_ov, rx_ob;
   logic rx2_ov, rx2_ob;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   logic [16:0] model;
   logic        sent [MAXBITS];
   int          wr_idx = 0;
   int          rd_idx = 0;
   bit          mon_on = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ssr_randomizer #(.SEED(SEED_A), .MODE(ssr_pkg::SSR_SCRAMBLE)) u_dut (
      .clk(clk), .rst(rst), .in_valid(tx_iv), .in_bit(tx_ib),
      .out_valid(tx_ov), .out_bit(tx_ob));

   ssr_randomizer #(.SEED(SEED_A), .MODE(ssr_pkg::SSR_DESCRAMBLE)) u_rx (
      .clk(clk), .rst(rst), .in_valid(tx_ov), .in_bit(tx_ob),
      .out_valid(rx_ov), .out_bit(rx_ob));

   ssr_randomizer #(.SEED(SEED_B), .MODE(ssr_pkg::SSR_DESCRAMBLE)) u_rx2 (
      .clk(clk), .rst(rst), .in_valid(tx_ov), .in_bit(tx_ob),
      .out_valid(rx2_ov), .out_bit(rx2_ob));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // scramble model step, from R2, R3, R4
   function automatic logic model_step(input logic b);
      logic o;
      o = b ^ model[11] ^ model[16];
      model = {model[15:0], o};
      return o;
   endfunction

   task automatic drive(input logic v, input logic b);
      tx_iv = v;
      tx_ib = b;
      if (v && mon_on && wr_idx < MAXBITS) begin
         sent[wr_idx] = b;
         wr_idx++;
      end
      @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; tx_iv = 1'b0; tx_ib = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
      model = SEED_A;
   endtask

   // chain monitor for R8 / R9
   always @(negedge clk) begin
      if (mon_on && rx_ov) begin
         chk(rx_ob == sent[rd_idx], "R8", int'(rx_ob), int'(sent[rd_idx]));
         if (rd_idx >= 17)
            chk(rx2_ob == sent[rd_idx], "R9", int'(rx2_ob), int'(sent[rd_idx]));
         rd_idx++;
      end
   end

   task automatic t_reset();
      do_reset();
      chk(tx_ov == 1'b0, "R1 out_valid after reset", int'(tx_ov), 0);
      chk(tx_ob == 1'b0, "R1 out_bit after reset", int'(tx_ob), 0);
      drive(1'b1, 1'b0);
      chk(tx_ob == (SEED_A[11] ^ SEED_A[16]), "R1 seed taps on first bit",
          int'(tx_ob), int'(SEED_A[11] ^ SEED_A[16]));
   endtask

   task automatic t_scramble_model();
      logic exp;
      do_reset();
      for (int i = 0; i < 60; i++) begin
         logic b;
         b = logic'($urandom_range(0, 1));
         exp = model_step(b);
         drive(1'b1, b);
         chk(tx_ov == 1'b1, "R6 valid follows", int'(tx_ov), 1);
         chk(tx_ob == exp, "R2 R3 R4 scramble bit", int'(tx_ob), int'(exp));
      end
      drive(1'b0, 1'b0);
      chk(tx_ov == 1'b0, "R6 valid drops", int'(tx_ov), 0);
   endtask

   task automatic t_idle_hold();
      logic exp, held;
      do_reset();
      for (int i = 0; i < 30; i++) begin
         logic b;
         b = logic'(i % 3 == 0);
         exp = model_step(b);
         drive(1'b1, b);
         chk(tx_ob == exp, "R2 pre-gap bit", int'(tx_ob), int'(exp));
         held = tx_ob;
         for (int g = 0; g < (i % 4); g++) begin
            drive(1'b0, ~b);
            chk(tx_ob == held, "R7 out_bit held while idle", int'(tx_ob), int'(held));
            chk(tx_ov == 1'b0, "R6 idle valid low", int'(tx_ov), 0);
         end
      end
   endtask

   task automatic t_chain();
      do_reset();
      wr_idx = 0; rd_idx = 0; mon_on = 1'b1;
      for (int i = 0; i < 300; i++) begin
         drive(1'b1, logic'($urandom_range(0, 1)));
         for (int g = 0; g < int'($urandom_range(0, 3)); g++) drive(1'b0, 1'b0);
      end
      for (int i = 0; i < 4; i++) drive(1'b0, 1'b0);
      mon_on = 1'b0;
      chk(rd_idx == wr_idx, "R8 all bits recovered", rd_idx, wr_idx);
   endtask

   task automatic t_zero_input();
      int ones;
      logic exp;
      do_reset();
      ones = 0;
      for (int i = 0; i < 40; i++) begin
         exp = model_step(1'b0);
         drive(1'b1, 1'b0);
         chk(tx_ob == exp, "R10 zero stream bit", int'(tx_ob), int'(exp));
         if (tx_ob) ones++;
      end
      chk(ones > 0 && ones < 40, "R10 output not constant", ones, 20);
   endtask

   initial begin
      t_reset();
      t_scramble_model();
      t_idle_hold();
      t_chain();
      t_zero_input();
      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!finished) begin
         finished = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

endmodule